// File: doc/BRIEF.md
# USB PHY Clock Control Register

This block is one configuration register that steers the clocks of two USB PHYs: a high-speed PHY with an internal PLL and a full-speed PHY. Software picks the reference source of each PHY, states the reference frequency, and brings the high-speed PHY PLL up or down. A behavioural lock model stands in for the analog PLL. It raises a read-only clock-good flag after a programmable number of cycles. The PLL must be running and the USB subsystem module clock must be on while those cycles count.

The register is shared with other users. Every write therefore carries a per-bit mask, and only bits whose mask bit is 1 take the new value. Bringing the PLL up is one masked write that clears reset and power-down and sets PLL-on. Software then polls for clock-good, with a time limit of 500 ms. The module clock is needed only until lock is reached. Taking the PLL down is a write that sets only power-down. The PLL output is always 48 MHz whatever valid reference is used. The register port is a plain, single-cycle write with a combinational read, so it has no back-pressure and no handshake.

Top module: `usbphy_clkctl`

## Requirements
- R1: After reset the register reads 0x0000_0180: reset (bit 8) and power-down (bit 7) are 1 and all other bits are 0. clk_good is 0, hs_from_aux is 0, fs_from_pll is 1 and ref_valid is 1.
- R2: A write changes exactly the bits whose wr_mask bit is 1. Every other bit keeps its value, including the general bits 31:10 that other users own.
- R3: Bit 9 reads the clock-good flag, and writes to bit 9 have no effect.
- R4: Bit 4 is the high-speed PHY mux. 0 selects the external reference and 1 selects the auxiliary bypass clock, and hs_from_aux equals bit 4.
- R5: Bit 5 is the full-speed PHY mux with the opposite sense. 1 selects the external reference and 0 selects the high-speed PHY PLL output, so fs_from_pll is the inverse of bit 5.
- R6: Bits 3:0 hold the reference code. Codes 0 to 8 stand for 12, 13, 19.2, 20, 24, 26, 38.4, 40 and 48 MHz in that order. ref_valid is 1 exactly for codes 0 to 8.
- R7: The PLL runs when PLL-on (bit 6) is 1, power-down and reset are 0, and the code is valid. From the write edge that makes it run, with mod_clk_en high, clk_good rises exactly lock_cycles clock edges later. A lock_cycles of 0 acts as 1.
- R8: While the PLL runs, lock counting pauses while mod_clk_en is low and resumes from the same count when it returns.
- R9: Once clk_good is 1, it stays 1 while the PLL keeps running, even with mod_clk_en low.
- R10: Setting power-down, setting reset or clearing PLL-on drops clk_good in the cycle the write lands. A later lock counts again from zero.
- R11: An invalid reference code (9 to 15) prevents lock and clears clk_good in the cycle the write lands.
- R12: A disable write (mask and data both 0x080) sets only power-down and leaves PLL-on, the muxes and the code unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_data | input | DATA_W | Write data |
| wr_mask | input | DATA_W | Per-bit write enable |
| rd_data | output | DATA_W | Current register value, with clock-good in bit 9 |
| mod_clk_en | input | 1 | USB subsystem module clock is on |
| lock_cycles | input | CNT_W | Cycles the PLL needs to lock |
| hs_from_aux | output | 1 | High-speed PHY uses the auxiliary bypass clock |
| fs_from_pll | output | 1 | Full-speed PHY uses the high-speed PHY PLL output |
| phy_pll_on | output | 1 | PLL-on field to the PHY |
| phy_pdown | output | 1 | Power-down field to the PHY |
| phy_reset | output | 1 | Reset field to the PHY |
| ref_code | output | 4 | Reference frequency code to the PHY |
| ref_valid | output | 1 | Reference code is one of the nine legal codes |
| clk_good | output | 1 | PLL lock reached and PLL still running |

## Verification
Masked writes are driven with masks that cover only the muxes, only the code, only the shared upper bits, only the read-only flag, all bits and no bits. This separates correct merging from whole-word writes and from writes that leak into the flag. Lock timing is probed one cycle before and at the expected edge, with mod_clk_en held high, paused mid-count and dropped after lock. These patterns separate pausing from clearing the count and sticky lock from a flag that needs the module clock. Each way of stopping the PLL is tried on its own: power-down, reset, PLL-on and an illegal code. A relock after each one shows that the count restarts from zero.

// File: rtl/usbclk_pkg.sv
package usbclk_pkg;
  // Field positions; the PHY decodes these bits, so they are fixed.
  localparam int REF_LSB    = 0;
  localparam int REF_W      = 4;
  localparam int HS_MUX_BIT = 4;
  localparam int FS_MUX_BIT = 5;
  localparam int PLLON_BIT  = 6;
  localparam int PDOWN_BIT  = 7;
  localparam int RESET_BIT  = 8;
  localparam int GOOD_BIT   = 9;
  localparam int FIELD_W    = RESET_BIT + 1;
  localparam int NUM_REF_CODES = 9;

  typedef enum logic [REF_W-1:0] {
    REF_12M  = 4'd0,
    REF_13M  = 4'd1,
    REF_19M2 = 4'd2,
    REF_20M  = 4'd3,
    REF_24M  = 4'd4,
    REF_26M  = 4'd5,
    REF_38M4 = 4'd6,
    REF_40M  = 4'd7,
    REF_48M  = 4'd8
  } ref_code_e;

  typedef struct packed {
    logic             phy_reset;
    logic             pdown;
    logic             pll_on;
    logic             fs_mux;
    logic             hs_mux;
    logic [REF_W-1:0] ref_code;
  } phy_fields_t;
endpackage

// File: rtl/usbclk_regfile.sv
module usbclk_regfile
  import usbclk_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [DATA_W-1:0] wr_mask,
  input  logic              clk_good,
  output logic [DATA_W-1:0] rd_data,
  output phy_fields_t       fields
);
  localparam logic [DATA_W-1:0] ONE     = {{(DATA_W-1){1'b0}}, 1'b1};
  localparam logic [DATA_W-1:0] RO_MASK = ONE << GOOD_BIT;
  localparam logic [DATA_W-1:0] RST_VAL = (ONE << PDOWN_BIT) | (ONE << RESET_BIT);

  logic [DATA_W-1:0] reg_q;
  logic [DATA_W-1:0] merged;

  always_comb begin
    merged = ((reg_q & ~wr_mask) | (wr_data & wr_mask)) & ~RO_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     reg_q <= RST_VAL;
    else if (wr_en) reg_q <= merged;
  end

  always_comb begin
    rd_data = reg_q | ({{(DATA_W-1){1'b0}}, clk_good} << GOOD_BIT);
    fields  = phy_fields_t'(reg_q[FIELD_W-1:0]);
  end

  // R2: unmasked bits survive a write
  assert_masked_keep_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (((reg_q ^ $past(reg_q)) & ~$past(wr_mask)) == '0));

  // R2: no write, no change
  assert_idle_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(reg_q));
endmodule

// File: rtl/usbclk_decode.sv
module usbclk_decode
  import usbclk_pkg::*;
(
  input  phy_fields_t      fields,
  output logic             hs_from_aux,
  output logic             fs_from_pll,
  output logic             ref_valid,
  output logic             pll_run
);
  always_comb begin
    hs_from_aux = fields.hs_mux;
    fs_from_pll = ~fields.fs_mux;
    ref_valid   = (fields.ref_code < REF_W'(NUM_REF_CODES));
    pll_run     = fields.pll_on & ~fields.pdown & ~fields.phy_reset & ref_valid;
  end
endmodule

// File: rtl/usbclk_lock.sv
module usbclk_lock #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pll_run,
  input  logic             mod_clk_en,
  input  logic [CNT_W-1:0] lock_cycles,
  output logic             clk_good
);
  logic [CNT_W-1:0] cnt_q;
  logic             locked_q;
  logic [CNT_W:0]   cnt_next;

  always_comb cnt_next = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      locked_q <= 1'b0;
    end else if (!pll_run) begin
      cnt_q    <= '0;
      locked_q <= 1'b0;
    end else if (!locked_q && mod_clk_en) begin
      cnt_q <= cnt_next[CNT_W-1:0];
      if (cnt_next >= {1'b0, lock_cycles}) locked_q <= 1'b1;
    end
  end

  assign clk_good = locked_q & pll_run;

  // R8: lock is reached only on a counting cycle with the module clock on
  assert_lock_needs_modclk_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked_q) |-> ($past(mod_clk_en) && $past(pll_run)));

  // R9: lock is sticky while the PLL runs
  assert_lock_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_q && pll_run) |=> locked_q);

  // R10: stopping the PLL clears lock and count
  assert_stop_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !pll_run |=> (!locked_q && cnt_q == '0));
endmodule

// File: rtl/usbphy_clkctl.sv
module usbphy_clkctl
  import usbclk_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [DATA_W-1:0] wr_mask,
  output logic [DATA_W-1:0] rd_data,
  input  logic              mod_clk_en,
  input  logic [CNT_W-1:0]  lock_cycles,
  output logic              hs_from_aux,
  output logic              fs_from_pll,
  output logic              phy_pll_on,
  output logic              phy_pdown,
  output logic              phy_reset,
  output logic [3:0]        ref_code,
  output logic              ref_valid,
  output logic              clk_good
);
  phy_fields_t fields;
  logic        pll_run;

  usbclk_regfile #(.DATA_W(DATA_W)) u_regfile (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .wr_mask  (wr_mask),
    .clk_good (clk_good),
    .rd_data  (rd_data),
    .fields   (fields)
  );

  usbclk_decode u_decode (
    .fields      (fields),
    .hs_from_aux (hs_from_aux),
    .fs_from_pll (fs_from_pll),
    .ref_valid   (ref_valid),
    .pll_run     (pll_run)
  );

  usbclk_lock #(.CNT_W(CNT_W)) u_lock (
    .clk         (clk),
    .rst_n       (rst_n),
    .pll_run     (pll_run),
    .mod_clk_en  (mod_clk_en),
    .lock_cycles (lock_cycles),
    .clk_good    (clk_good)
  );

  always_comb begin
    phy_pll_on = fields.pll_on;
    phy_pdown  = fields.pdown;
    phy_reset  = fields.phy_reset;
    ref_code   = fields.ref_code;
  end

  // R11: lock is never reported on an illegal reference code
  assert_good_valid_ref_R11: assert property (@(posedge clk) disable iff (!rst_n)
    clk_good |-> ref_valid);

  // R3: the read-back flag tracks clk_good
  assert_flag_readback_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[GOOD_BIT] == clk_good);
endmodule

// File: tb/test_usbphy_clkctl.sv
module test_usbphy_clkctl;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  // {mask, data}
  localparam logic [63:0] VEC [NVEC] = '{
    {32'h0000_0030, 32'h0000_0010},
    {32'h0000_000F, 32'h0000_0008},
    {32'hFFFF_FC00, 32'hA5A5_A400},
    {32'h0000_0030, 32'h0000_0020},
    {32'h0000_000F, 32'h0000_000C},
    {32'h0000_0200, 32'h0000_0200},
    {32'hFFFF_FFFF, 32'h0000_0000},
    {32'h0000_0000, 32'hFFFF_FFFF}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] wr_mask = '0;
  logic [31:0] rd_data;
  logic        mod_clk_en = 1'b0;
  logic [15:0] lock_cycles = 16'd1000;
  logic        hs_from_aux, fs_from_pll, phy_pll_on, phy_pdown, phy_reset;
  logic [3:0]  ref_code;
  logic        ref_valid, clk_good;

  int n_checks = 0;
  int n_fail   = 0;
  logic [31:0] model = 32'h0000_0180;

  always #(CLK_PERIOD/2) clk = ~clk;

  usbphy_clkctl i_usbphy_clkctl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .wr_mask(wr_mask), .rd_data(rd_data), .mod_clk_en(mod_clk_en),
    .lock_cycles(lock_cycles), .hs_from_aux(hs_from_aux),
    .fs_from_pll(fs_from_pll), .phy_pll_on(phy_pll_on),
    .phy_pdown(phy_pdown), .phy_reset(phy_reset), .ref_code(ref_code),
    .ref_valid(ref_valid), .clk_good(clk_good)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] m, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_mask = m; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    model = ((model & ~m) | (d & m)) & ~32'h0000_0200;
  endtask

  task automatic check_fields(input string req);
    check(req, rd_data & ~32'h200, model);
    check({req, " hs mux R4"}, {31'd0, hs_from_aux}, {31'd0, model[4]});
    check({req, " fs mux R5"}, {31'd0, fs_from_pll}, {31'd0, ~model[5]});
    check({req, " code R6"}, {31'd0, ref_valid}, {31'd0, model[3:0] < 4'd9});
    check({req, " pins"}, {27'd0, phy_reset, phy_pdown, phy_pll_on, ref_code},
          {27'd0, model[8], model[7], model[6], model[3:0]});
  endtask

  initial begin
    repeat (CLK_PERIOD * 20000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 reset value", rd_data, 32'h0000_0180);
    check("R1 clk_good", {31'd0, clk_good}, 32'd0);
    check("R1 outputs", {29'd0, hs_from_aux, fs_from_pll, ref_valid}, 32'b011);

    // R2/R4/R5/R6 table of masked writes
    for (int i = 0; i < NVEC; i++) begin
      wr(VEC[i][63:32], VEC[i][31:0]);
      check_fields("R2 masked write");
      check("R3 flag reads 0", {31'd0, rd_data[9]}, 32'd0);
    end

    // R7 lock timing
    mod_clk_en = 1'b1; lock_cycles = 16'd5;
    wr(32'h0000_01FF, 32'h0000_0044);
    repeat (4) @(negedge clk);
    check("R7 not yet locked", {31'd0, clk_good}, 32'd0);
    @(negedge clk);
    check("R7 locked at lock_cycles", {31'd0, clk_good}, 32'd1);
    check("R3 flag readback", {31'd0, rd_data[9]}, 32'd1);

    // R3 write to flag bit ignored
    wr(32'h0000_0200, 32'h0000_0000);
    check("R3 flag write ignored", {31'd0, rd_data[9]}, 32'd1);

    // R12 disable sets only power-down; R10 drop same cycle
    wr(32'h0000_0080, 32'h0000_0080);
    check("R12 disable value", rd_data, 32'h0000_00C4);
    check("R10 pdown clears good", {31'd0, clk_good}, 32'd0);

    // R8 pause then resume
    mod_clk_en = 1'b0; lock_cycles = 16'd3;
    wr(32'h0000_0080, 32'h0000_0000);
    mod_clk_en = 1'b1;
    @(negedge clk);
    mod_clk_en = 1'b0;
    repeat (5) @(negedge clk);
    check("R8 paused no lock", {31'd0, clk_good}, 32'd0);
    mod_clk_en = 1'b1;
    @(negedge clk);
    check("R8 resumed count 2", {31'd0, clk_good}, 32'd0);
    @(negedge clk);
    check("R8 resumed lock", {31'd0, clk_good}, 32'd1);

    // R9 sticky without module clock
    mod_clk_en = 1'b0;
    repeat (10) @(negedge clk);
    check("R9 sticky lock", {31'd0, clk_good}, 32'd1);

    // R10 reset bit, then relock from zero, then PLL-on cleared
    mod_clk_en = 1'b1;
    wr(32'h0000_0100, 32'h0000_0100);
    check("R10 reset clears good", {31'd0, clk_good}, 32'd0);
    wr(32'h0000_0100, 32'h0000_0000);
    repeat (2) @(negedge clk);
    check("R10 relock from zero early", {31'd0, clk_good}, 32'd0);
    @(negedge clk);
    check("R10 relock", {31'd0, clk_good}, 32'd1);
    wr(32'h0000_0040, 32'h0000_0000);
    check("R10 pll off clears good", {31'd0, clk_good}, 32'd0);

    // R11 invalid code
    wr(32'h0000_004F, 32'h0000_004C);
    repeat (10) @(negedge clk);
    check("R11 invalid code no lock", {30'd0, clk_good, ref_valid}, 32'd0);
    wr(32'h0000_000F, 32'h0000_0000);
    repeat (3) @(negedge clk);
    check("R11 valid code locks", {31'd0, clk_good}, 32'd1);
    wr(32'h0000_000F, 32'h0000_000F);
    check("R11 invalid code clears", {31'd0, clk_good}, 32'd0);

    // R7 lock_cycles of zero acts as one
    lock_cycles = 16'd0;
    wr(32'h0000_000F, 32'h0000_0008);
    check("R7 zero limit write cycle", {31'd0, clk_good}, 32'd0);
    @(negedge clk);
    check("R7 zero limit acts as one", {31'd0, clk_good}, 32'd1);
    check_fields("R6 48 MHz code");

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule